// File: doc/BRIEF.md
# Dual-Issue Pairing and Pipe Steering

This block sits behind a two-slot instruction register in an in-order, two-wide pipeline. Every cycle it looks at the older and the younger decoded instruction and decides whether to issue none, one or both. It then sends each issued instruction to one of two execution pipes. The two pipes do different work. Pipe A can run ALU and memory operations. Pipe B can run ALU operations and branches.

The pairing decision has three inputs: a read-after-write check between the two slots, a structural check on the operation classes, and program order. The number of instructions taken is reported in the same cycle, so the instruction register can move the leftover instruction into the older slot. Pipe assignments are captured in a pair of issue registers that feed the pipes. These registers hold their contents while the downstream stall is high.

Top module: `pair_issue_steer`

## Requirements
- R1: Class encoding is 0 = ALU, 1 = memory, 2 = branch, 3 = ALU. A memory operation always goes to pipe A and a branch always goes to pipe B.
- R2: When the older slot is valid and there is no stall, the older instruction issues, so `consumed_o` is at least 1.
- R3: If the younger instruction reads a register that the older one writes, only the older instruction issues.
- R4: If both instructions are memory operations, or both are branches, only the older instruction issues.
- R5: When the older slot is invalid, nothing issues. The younger instruction never issues without the older one.
- R6: While `stall_i` is high, `consumed_o` is 0 and the pipe outputs keep their previous values.
- R7: When both issue, the ALU instruction takes the pipe the other one does not need. An older ALU instruction takes pipe B only when the younger one is a memory operation. An ALU instruction issued alone goes to pipe A.
- R8: `consumed_o` is combinational and equals the number issued. On the next clock edge each pipe's valid and select outputs are loaded, where select 0 means the older slot and 1 means the younger slot.
- R9: After reset both pipe valid outputs are low.
- R10: A younger source register counts toward the hazard only when its use bit is set (bit 0 for the first source, bit 1 for the second). The older destination counts only when its write-enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stall_i | input | 1 | Downstream stall |
| old_valid_i | input | 1 | Older slot holds an instruction |
| old_cls_i | input | 2 | Older operation class |
| old_rd_i | input | REG_AW | Older destination register |
| old_we_i | input | 1 | Older writes its destination |
| yng_valid_i | input | 1 | Younger slot holds an instruction |
| yng_cls_i | input | 2 | Younger operation class |
| yng_rs1_i | input | REG_AW | Younger first source register |
| yng_rs2_i | input | REG_AW | Younger second source register |
| yng_use_i | input | 2 | Younger source use bits |
| consumed_o | output | 2 | Instructions taken this cycle |
| pipe_a_valid_o | output | 1 | Pipe A holds an issued instruction |
| pipe_a_sel_o | output | 1 | Slot that fed pipe A |
| pipe_b_valid_o | output | 1 | Pipe B holds an issued instruction |
| pipe_b_sel_o | output | 1 | Slot that fed pipe B |

## Verification
The assertions check the following on every cycle:
- The issue count stays within range and is zero during stall or when the older slot is empty.
- A pair never forms across a hazard or a class conflict.
- Memory operations and branches land in their own pipes.
- Pipe outputs hold during stall.

Some behaviours are shown only by the bench's sweep over classes, valid bits, register overlaps and use bits:
- An ALU instruction is placed in whichever pipe its partner leaves free.
- Source use bits and the destination write-enable gate the hazard.

// File: rtl/dual_issue_pkg.sv
package dual_issue_pkg;
  typedef enum logic [1:0] {
    CLS_ALU  = 2'd0,
    CLS_MEM  = 2'd1,
    CLS_BR   = 2'd2,
    CLS_ALU2 = 2'd3
  } op_cls_e;

  localparam int unsigned N_SRC = 2;

  function automatic logic is_alu(input logic [1:0] c);
    return (c == CLS_ALU) || (c == CLS_ALU2);
  endfunction
endpackage

// File: rtl/dual_issue_raw_chk.sv
module dual_issue_raw_chk
  import dual_issue_pkg::*;
#(
  parameter int unsigned REG_AW = 5
) (
  input  logic [REG_AW-1:0] old_rd_i,
  input  logic              old_we_i,
  input  logic [REG_AW-1:0] yng_rs1_i,
  input  logic [REG_AW-1:0] yng_rs2_i,
  input  logic [N_SRC-1:0]  yng_use_i,
  output logic              raw_o
);
  logic [REG_AW-1:0] src [N_SRC];
  logic [N_SRC-1:0]  hit;

  assign src[0] = yng_rs1_i;
  assign src[1] = yng_rs2_i;

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    assign hit[g] = yng_use_i[g] && (src[g] == old_rd_i);
  end

  assign raw_o = old_we_i && (|hit);
endmodule

// File: rtl/dual_issue_steer.sv
module dual_issue_steer
  import dual_issue_pkg::*;
(
  input  logic [1:0] old_cls_i,
  input  logic [1:0] yng_cls_i,
  input  logic       pair_i,
  output logic       cls_ok_o,
  output logic       old_to_b_o
);
  logic old_mem, old_br, yng_mem, yng_br;

  assign old_mem = (old_cls_i == CLS_MEM);
  assign old_br  = (old_cls_i == CLS_BR);
  assign yng_mem = (yng_cls_i == CLS_MEM);
  assign yng_br  = (yng_cls_i == CLS_BR);

  // each single-capable pipe can take only one of the pair
  assign cls_ok_o = !(old_mem && yng_mem) && !(old_br && yng_br);

  // older ALU yields pipe A only to a paired younger memory op
  assign old_to_b_o = old_br || (is_alu(old_cls_i) && pair_i && yng_mem);
endmodule

// File: rtl/pair_issue_steer.sv
module pair_issue_steer
  import dual_issue_pkg::*;
#(
  parameter int unsigned REG_AW = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stall_i,
  input  logic              old_valid_i,
  input  logic [1:0]        old_cls_i,
  input  logic [REG_AW-1:0] old_rd_i,
  input  logic              old_we_i,
  input  logic              yng_valid_i,
  input  logic [1:0]        yng_cls_i,
  input  logic [REG_AW-1:0] yng_rs1_i,
  input  logic [REG_AW-1:0] yng_rs2_i,
  input  logic [1:0]        yng_use_i,
  output logic [1:0]        consumed_o,
  output logic              pipe_a_valid_o,
  output logic              pipe_a_sel_o,
  output logic              pipe_b_valid_o,
  output logic              pipe_b_sel_o
);
  logic raw, cls_ok, old_to_b;
  logic iss_old, iss_yng;
  logic a_take, a_sel_n, b_take, b_sel_n;

  dual_issue_raw_chk #(.REG_AW(REG_AW)) u_raw (
    .old_rd_i  (old_rd_i),
    .old_we_i  (old_we_i),
    .yng_rs1_i (yng_rs1_i),
    .yng_rs2_i (yng_rs2_i),
    .yng_use_i (yng_use_i),
    .raw_o     (raw)
  );

  dual_issue_steer u_steer (
    .old_cls_i  (old_cls_i),
    .yng_cls_i  (yng_cls_i),
    .pair_i     (iss_yng),
    .cls_ok_o   (cls_ok),
    .old_to_b_o (old_to_b)
  );

  assign iss_old    = old_valid_i && !stall_i;
  assign iss_yng    = iss_old && yng_valid_i && !raw && cls_ok;
  assign consumed_o = {1'b0, iss_old} + {1'b0, iss_yng};

  // younger always takes the pipe the older one leaves
  assign a_take  = (iss_old && !old_to_b) || (iss_yng && old_to_b);
  assign a_sel_n = !(iss_old && !old_to_b);
  assign b_take  = (iss_old && old_to_b) || (iss_yng && !old_to_b);
  assign b_sel_n = !(iss_old && old_to_b);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pipe_a_valid_o <= 1'b0;
      pipe_a_sel_o   <= 1'b0;
      pipe_b_valid_o <= 1'b0;
      pipe_b_sel_o   <= 1'b0;
    end else if (!stall_i) begin
      pipe_a_valid_o <= a_take;
      pipe_a_sel_o   <= a_take ? a_sel_n : 1'b0;
      pipe_b_valid_o <= b_take;
      pipe_b_sel_o   <= b_take ? b_sel_n : 1'b0;
    end
  end
endmodule

// File: rtl/pair_issue_steer_sva.sv
module pair_issue_steer_sva #(
  parameter int unsigned REG_AW = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              stall_i,
  input logic              old_valid_i,
  input logic [1:0]        old_cls_i,
  input logic [REG_AW-1:0] old_rd_i,
  input logic              old_we_i,
  input logic              yng_valid_i,
  input logic [1:0]        yng_cls_i,
  input logic [REG_AW-1:0] yng_rs1_i,
  input logic [REG_AW-1:0] yng_rs2_i,
  input logic [1:0]        yng_use_i,
  input logic [1:0]        consumed_o,
  input logic              pipe_a_valid_o,
  input logic              pipe_a_sel_o,
  input logic              pipe_b_valid_o,
  input logic              pipe_b_sel_o
);
  logic yng_reads_old;
  assign yng_reads_old = old_we_i &&
    ((yng_use_i[0] && yng_rs1_i == old_rd_i) || (yng_use_i[1] && yng_rs2_i == old_rd_i));

  // R8
  count_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    consumed_o != 2'd3);

  // R2
  older_issues_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (old_valid_i && !stall_i) |-> consumed_o != 2'd0);

  // R5
  order_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !old_valid_i |-> consumed_o == 2'd0);

  // R3
  raw_split_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    yng_reads_old |-> consumed_o != 2'd2);

  // R4
  cls_split_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (old_cls_i == yng_cls_i && (old_cls_i == 2'd1 || old_cls_i == 2'd2)) |-> consumed_o != 2'd2);

  // R6
  stall_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |-> consumed_o == 2'd0);

  // R6
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |=> $stable({pipe_a_valid_o, pipe_a_sel_o, pipe_b_valid_o, pipe_b_sel_o}));

  // R1
  mem_to_a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (consumed_o != 2'd0 && old_cls_i == 2'd1) |=> (pipe_a_valid_o && !pipe_a_sel_o));

  // R1
  br_to_b_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (consumed_o != 2'd0 && old_cls_i == 2'd2) |=> (pipe_b_valid_o && !pipe_b_sel_o));

  // R8
  pair_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (consumed_o == 2'd2) |=> (pipe_a_valid_o && pipe_b_valid_o && pipe_a_sel_o != pipe_b_sel_o));

  // R8
  idle_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_i && consumed_o == 2'd0) |=> (!pipe_a_valid_o && !pipe_b_valid_o));
endmodule

bind pair_issue_steer pair_issue_steer_sva #(.REG_AW(REG_AW)) u_sva (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .stall_i        (stall_i),
  .old_valid_i    (old_valid_i),
  .old_cls_i      (old_cls_i),
  .old_rd_i       (old_rd_i),
  .old_we_i       (old_we_i),
  .yng_valid_i    (yng_valid_i),
  .yng_cls_i      (yng_cls_i),
  .yng_rs1_i      (yng_rs1_i),
  .yng_rs2_i      (yng_rs2_i),
  .yng_use_i      (yng_use_i),
  .consumed_o     (consumed_o),
  .pipe_a_valid_o (pipe_a_valid_o),
  .pipe_a_sel_o   (pipe_a_sel_o),
  .pipe_b_valid_o (pipe_b_valid_o),
  .pipe_b_sel_o   (pipe_b_sel_o)
);

// File: tb/pair_issue_steer_bench.sv
module pair_issue_steer_bench;
  localparam int unsigned AW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stall = 1'b0;
  logic ov = 1'b0, owe = 1'b0, yv = 1'b0;
  logic [1:0] oc = '0, yc = '0, yuse = '0;
  logic [AW-1:0] ord = '0, yr1 = '0, yr2 = '0;
  logic [1:0] cons;
  logic av, as, bv, bs;

  int checks = 0, errors = 0;
  logic e_av = 0, e_as = 0, e_bv = 0, e_bs = 0;
  string ptag = "R9";

  always #10 clk = ~clk;

  pair_issue_steer #(.REG_AW(AW)) u_pair_issue_steer (
    .clk_i(clk), .rst_ni(rst_n), .stall_i(stall),
    .old_valid_i(ov), .old_cls_i(oc), .old_rd_i(ord), .old_we_i(owe),
    .yng_valid_i(yv), .yng_cls_i(yc), .yng_rs1_i(yr1), .yng_rs2_i(yr2),
    .yng_use_i(yuse), .consumed_o(cons),
    .pipe_a_valid_o(av), .pipe_a_sel_o(as), .pipe_b_valid_o(bv), .pipe_b_sel_o(bs)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic chk_pipes();
    chk(ptag, "pipe_a_valid", int'(av), int'(e_av));
    chk(ptag, "pipe_a_sel",   int'(as), int'(e_as));
    chk(ptag, "pipe_b_valid", int'(bv), int'(e_bv));
    chk(ptag, "pipe_b_sel",   int'(bs), int'(e_bs));
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog run did not finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R9: reset state
    #25;
    chk("R9", "reset pipe_a_valid", int'(av), 0);
    chk("R9", "reset pipe_b_valid", int'(bv), 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int v = 0; v < 4; v++)
    for (int c0 = 0; c0 < 4; c0++)
    for (int c1 = 0; c1 < 4; c1++)
    for (int st = 0; st < 2; st++)
    for (int we = 0; we < 2; we++)
    for (int us = 0; us < 4; us++)
    for (int r1 = 0; r1 < 4; r1++) begin
      bit raw, clsok, i0, i1, o2b, alias_only;
      string t;
      @(negedge clk);
      chk_pipes();
      ov = v[0]; yv = v[1]; oc = c0[1:0]; yc = c1[1:0];
      stall = st[0]; owe = we[0]; yuse = us[1:0];
      ord = 2'd2; yr1 = r1[AW-1:0]; yr2 = 2'd3 - r1[AW-1:0];
      raw = we[0] && ((us[0] && r1 == 2) || (us[1] && (3 - r1) == 2));
      alias_only = !raw && (r1 == 2 || (3 - r1) == 2);
      clsok = !(c0 == 1 && c1 == 1) && !(c0 == 2 && c1 == 2);
      i0 = v[0] && !st[0];
      i1 = i0 && v[1] && !raw && clsok;
      if (st[0]) t = "R6";
      else if (!v[0]) t = "R5";
      else if (v[1] && raw) t = "R3";
      else if (v[1] && !clsok) t = "R4";
      else if (v[1] && alias_only) t = "R10";
      else t = "R2";
      #2;
      chk(t, "consumed", int'(cons), int'(i0) + int'(i1));
      // model next pipe state
      if (!st[0]) begin
        o2b = (c0 == 2) || ((c0 == 0 || c0 == 3) && i1 && c1 == 1);
        e_av = 0; e_as = 0; e_bv = 0; e_bs = 0;
        if (i0) begin
          if (o2b) begin e_bv = 1; e_bs = 0; end
          else     begin e_av = 1; e_as = 0; end
        end
        if (i1) begin
          if (o2b) begin e_av = 1; e_as = 1; end
          else     begin e_bv = 1; e_bs = 1; end
        end
        if (c0 == 1 || c0 == 2 || (i1 && (c1 == 1 || c1 == 2))) ptag = "R1";
        else if (i1) ptag = "R7";
        else ptag = "R8";
      end else ptag = "R6";
    end
    @(negedge clk);
    chk_pipes();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule